// File: doc/BRIEF.md
# Circular Receive-Buffer Address Generator

This block sits on the receive path between a payload beat stream and the internal packet router. It cuts the incoming stream into internal packets. In front of each packet it puts one header beat. The header carries the port id, the target memory (host or accelerator) and the virtual address where the payload must land. No software takes part per packet: the address comes from walking a circular list of equal-sized receive buffers. That list is described by a base address, a per-buffer size in beats and a buffer count.

A buffer is closed in one of two ways. It can fill completely, or it can stay partly filled and idle for a configured number of cycles. Either way the block emits a one-cycle completion event carrying the buffer index and its number of valid bytes, and the next packet starts at offset zero of the following buffer. After the last buffer the walk returns to buffer zero. A packet never crosses a buffer edge: it is shortened to the room left, and the buffer then closes.

Configuration is loaded through a parallel load strobe and takes effect only while the block is disabled. Disabling the block clears its walk state, so a new enable always starts at buffer zero, offset zero. A beat is 8 bytes.

Top module: `rx_ring_addr_gen`

## Requirements
- R1: After reset, in_ready_o, out_valid_o and evt_valid_o are low, and the configuration holds buffer size 1 beat, buffer count 1, packet size 1 beat, port 0, target 0 and timeout 0.
- R2: While enable_i is low, in_ready_o and out_valid_o are low. cfg_load_i is captured only while enable_i is low. A load presented while enabled has no effect on any later header.
- R3: Each packet opens with one header beat with out_valid_o and out_sop_o high and in_ready_o low, so no input is consumed in that cycle. Header layout: bit 63 target, bits 62:56 port, bits 55:8 virtual address, bits 7:0 payload length in beats. Payload beats follow with in_ready_o high, and each accepted beat is passed to out_data_o unchanged in the same cycle.
- R4: The header address equals base + 8 * (buffer_index * buffer_beats + fill_offset), where fill_offset counts the beats already written to the current buffer.
- R5: The payload length is min(packet_beats, buffer_beats - fill_offset). out_eop_o is high exactly on the last payload beat.
- R6: When the beat that fills a buffer is accepted, evt_valid_o pulses for one cycle after that clock edge. The pulse carries evt_index_o equal to the buffer index and evt_bytes_o equal to 8 * buffer_beats, and the next packet starts at offset 0 of the next buffer.
- R7: After the buffer with index count-1 closes, the next buffer index is 0 and its address is the base again.
- R8: The timeout applies when no packet is open, the current buffer holds data and in_valid_i stays low. After the configured number of such consecutive cycles, the buffer closes with an event carrying 8 * fill_offset bytes, visible after the clock edge of the last idle cycle.
- R9: No event is raised while the buffer is empty, while a packet is open, or when the timeout is 0. The idle count restarts whenever in_valid_i is high or a beat is accepted.
- R10: Deasserting enable_i clears the buffer index and fill offset, so after re-enabling, the first header address is the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low clears walk state and permits config loads |
| cfg_load_i | input | 1 | Configuration load strobe |
| cfg_base_i | input | 48 | Virtual base address of buffer 0 |
| cfg_buf_beats_i | input | 16 | Buffer size in 8-byte beats (at least 1) |
| cfg_buf_count_i | input | 8 | Number of buffers in the ring (at least 1) |
| cfg_pkt_beats_i | input | 8 | Maximum payload beats per packet (at least 1) |
| cfg_port_i | input | 7 | Port id written to headers |
| cfg_dev_i | input | 1 | Target memory: 1 accelerator, 0 host |
| cfg_timeout_i | input | 16 | Idle cycles before closing a partial buffer; 0 disables |
| in_valid_i | input | 1 | Payload beat valid |
| in_data_i | input | 64 | Payload beat |
| in_ready_o | output | 1 | Payload beat accepted when high with in_valid_i |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | 64 | Header or payload beat |
| out_sop_o | output | 1 | Marks the header beat |
| out_eop_o | output | 1 | Marks the last payload beat |
| evt_valid_o | output | 1 | One-cycle buffer-done event |
| evt_index_o | output | 8 | Index of the closed buffer |
| evt_bytes_o | output | 19 | Valid bytes in the closed buffer |

## Verification
The main function is driven with several input patterns, and each one separates a different behaviour. A gap-free stream tells a packet shortened by the buffer edge from a full-size packet, and shows the header bubble. Sparse beats with gaps just under the timeout tell a restarting idle count from one that accumulates. Long stalls inside an open packet and with an empty buffer tell a timeout limited to partial data at a packet boundary from one that fires anywhere. Random ring shapes cover one-beat buffers, packets larger than a buffer, and single-buffer rings, and check address arithmetic against a multiply-based reference at every wrap. A disable in the middle of a buffer, followed by a config load attempted while running, separates state clearing on disable from config that changes at run time.

// File: rtl/rrag_pkg.sv
package rrag_pkg;
  localparam int DATA_W     = 64;
  localparam int BEAT_SHIFT = 3;
  localparam int ADDR_W     = 48;
  localparam int PORT_W     = 7;
  localparam int LEN_W      = 8;
  localparam int BUF_W      = 16;
  localparam int IDX_W      = 8;
  localparam int TMO_W      = 16;
  localparam int BYTES_W    = BUF_W + BEAT_SHIFT;

  typedef struct packed {
    logic              dev;
    logic [PORT_W-1:0] port;
    logic [ADDR_W-1:0] vaddr;
    logic [LEN_W-1:0]  len;
  } hdr_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [BUF_W-1:0]  buf_beats;
    logic [IDX_W-1:0]  buf_count;
    logic [LEN_W-1:0]  pkt_beats;
    logic [PORT_W-1:0] port;
    logic              dev;
    logic [TMO_W-1:0]  timeout;
  } cfg_t;
endpackage

// File: rtl/rrag_cfg_regs.sv
module rrag_cfg_regs
  import rrag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic load_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q           <= '0;
      cfg_q.buf_beats <= BUF_W'(1);
      cfg_q.buf_count <= IDX_W'(1);
      cfg_q.pkt_beats <= LEN_W'(1);
    end else if (load_i && !enable_i) begin
      cfg_q <= cfg_i;
    end
  end

  assign cfg_o = cfg_q;

  assert_cfg_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && $past(enable_i)) |-> $stable(cfg_q));
endmodule

// File: rtl/rrag_ring_walker.sv
module rrag_ring_walker
  import rrag_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  cfg_t               cfg_i,
  input  logic               beat_fire_i,
  input  logic               idle_i,
  output logic [BUF_W-1:0]   room_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               evt_valid_o,
  output logic [IDX_W-1:0]   evt_idx_o,
  output logic [BYTES_W-1:0] evt_bytes_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [BUF_W-1:0]  off_q;
  logic [ADDR_W-1:0] rel_q;   // start of current buffer relative to base
  logic [TMO_W-1:0]  tmo_q;

  logic [BUF_W:0]    off_inc;
  logic [TMO_W:0]    tmo_inc;
  logic              partial, buf_full, tmo_hit, last_buf, close;
  logic [ADDR_W-1:0] buf_span;

  assign off_inc  = {1'b0, off_q} + 1'b1;
  assign tmo_inc  = {1'b0, tmo_q} + 1'b1;
  assign partial  = (off_q != '0);
  assign buf_full = beat_fire_i && (off_inc == {1'b0, cfg_i.buf_beats});
  assign tmo_hit  = idle_i && partial && (cfg_i.timeout != '0) &&
                    (tmo_inc == {1'b0, cfg_i.timeout});
  assign close    = buf_full || tmo_hit;
  assign last_buf = (idx_q == cfg_i.buf_count - 1'b1);
  assign buf_span = ADDR_W'(cfg_i.buf_beats) << BEAT_SHIFT;

  assign room_o = cfg_i.buf_beats - off_q;
  assign addr_o = cfg_i.base + rel_q + (ADDR_W'(off_q) << BEAT_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      off_q       <= '0;
      rel_q       <= '0;
      tmo_q       <= '0;
      evt_valid_o <= 1'b0;
      evt_idx_o   <= '0;
      evt_bytes_o <= '0;
    end else if (!enable_i) begin
      idx_q       <= '0;
      off_q       <= '0;
      rel_q       <= '0;
      tmo_q       <= '0;
      evt_valid_o <= 1'b0;
    end else begin
      evt_valid_o <= 1'b0;
      if (close) begin
        evt_valid_o <= 1'b1;
        evt_idx_o   <= idx_q;
        evt_bytes_o <= buf_full ? (BYTES_W'(cfg_i.buf_beats) << BEAT_SHIFT)
                                : (BYTES_W'(off_q) << BEAT_SHIFT);
        off_q <= '0;
        tmo_q <= '0;
        if (last_buf) begin
          idx_q <= '0;
          rel_q <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
          rel_q <= rel_q + buf_span;
        end
      end else if (beat_fire_i) begin
        off_q <= off_q + 1'b1;
        tmo_q <= '0;
      end else if (idle_i && partial) begin
        tmo_q <= tmo_q + 1'b1;
      end else begin
        tmo_q <= '0;
      end
    end
  end

  assert_off_in_buf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> (off_q < cfg_i.buf_beats));
  assert_idx_in_ring_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> (idx_q < cfg_i.buf_count));
  assert_evt_clears_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (off_q == '0));
  assert_evt_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o);
  assert_no_evt_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!evt_valid_o && off_q == '0 && idx_q == '0));
endmodule

// File: rtl/rrag_packetizer.sv
module rrag_packetizer
  import rrag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              dev_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [LEN_W-1:0]  pkt_beats_i,
  input  logic [BUF_W-1:0]  room_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              beat_fire_o,
  output logic              boundary_o
);
  logic             body_q;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] len;
  hdr_t             hdr;

  always_comb begin
    if (room_i < BUF_W'(pkt_beats_i)) len = room_i[LEN_W-1:0];
    else                              len = pkt_beats_i;
  end

  assign hdr         = {dev_i, port_i, addr_i, len};
  assign in_ready_o  = enable_i && body_q;
  assign out_valid_o = enable_i && in_valid_i;
  assign out_sop_o   = enable_i && !body_q && in_valid_i;
  assign out_eop_o   = enable_i && body_q && in_valid_i && (left_q == LEN_W'(1));
  assign out_data_o  = body_q ? in_data_i : DATA_W'(hdr);
  assign beat_fire_o = in_valid_i && in_ready_o;
  assign boundary_o  = !body_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      body_q <= 1'b0;
      left_q <= '0;
    end else if (!enable_i) begin
      body_q <= 1'b0;
      left_q <= '0;
    end else if (out_sop_o) begin
      body_q <= 1'b1;
      left_q <= len;
    end else if (beat_fire_o) begin
      left_q <= left_q - 1'b1;
      if (left_q == LEN_W'(1)) body_q <= 1'b0;
    end
  end

  assert_len_fits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> (len != '0 && BUF_W'(len) <= room_i && len <= pkt_beats_i));
  assert_body_has_left_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    body_q |-> (left_q != '0));
  assert_hdr_no_consume_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |=> (body_q && left_q == $past(len)));
endmodule

// File: rtl/rx_ring_addr_gen.sv
module rx_ring_addr_gen
  import rrag_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               cfg_load_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [BUF_W-1:0]   cfg_buf_beats_i,
  input  logic [IDX_W-1:0]   cfg_buf_count_i,
  input  logic [LEN_W-1:0]   cfg_pkt_beats_i,
  input  logic [PORT_W-1:0]  cfg_port_i,
  input  logic               cfg_dev_i,
  input  logic [TMO_W-1:0]   cfg_timeout_i,
  input  logic               in_valid_i,
  input  logic [DATA_W-1:0]  in_data_i,
  output logic               in_ready_o,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  out_data_o,
  output logic               out_sop_o,
  output logic               out_eop_o,
  output logic               evt_valid_o,
  output logic [IDX_W-1:0]   evt_index_o,
  output logic [BYTES_W-1:0] evt_bytes_o
);
  cfg_t              cfg_in, cfg;
  logic [BUF_W-1:0]  room;
  logic [ADDR_W-1:0] addr;
  logic              beat_fire, boundary, idle;

  always_comb begin
    cfg_in.base      = cfg_base_i;
    cfg_in.buf_beats = cfg_buf_beats_i;
    cfg_in.buf_count = cfg_buf_count_i;
    cfg_in.pkt_beats = cfg_pkt_beats_i;
    cfg_in.port      = cfg_port_i;
    cfg_in.dev       = cfg_dev_i;
    cfg_in.timeout   = cfg_timeout_i;
  end

  assign idle = enable_i && boundary && !in_valid_i;

  rrag_cfg_regs u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .load_i   (cfg_load_i),
    .cfg_i    (cfg_in),
    .cfg_o    (cfg)
  );

  rrag_ring_walker u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .cfg_i       (cfg),
    .beat_fire_i (beat_fire),
    .idle_i      (idle),
    .room_o      (room),
    .addr_o      (addr),
    .evt_valid_o (evt_valid_o),
    .evt_idx_o   (evt_index_o),
    .evt_bytes_o (evt_bytes_o)
  );

  rrag_packetizer u_pkt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .dev_i       (cfg.dev),
    .port_i      (cfg.port),
    .pkt_beats_i (cfg.pkt_beats),
    .room_i      (room),
    .addr_i      (addr),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_sop_o   (out_sop_o),
    .out_eop_o   (out_eop_o),
    .beat_fire_o (beat_fire),
    .boundary_o  (boundary)
  );

  assert_quiet_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (!out_valid_o && !in_ready_o));
  assert_no_evt_mid_pkt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !boundary && !beat_fire) |=> !evt_valid_o);
endmodule

// File: tb/sim_rx_ring_addr_gen.sv
`timescale 1ns/1ps
module sim_rx_ring_addr_gen;
  import rrag_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               en = 1'b0, cfg_load = 1'b0;
  logic [ADDR_W-1:0]  c_base = '0;
  logic [BUF_W-1:0]   c_buf = '0;
  logic [IDX_W-1:0]   c_cnt = '0;
  logic [LEN_W-1:0]   c_pkt = '0;
  logic [PORT_W-1:0]  c_port = '0;
  logic               c_dev = 1'b0;
  logic [TMO_W-1:0]   c_tmo = '0;
  logic               in_valid = 1'b0;
  logic [DATA_W-1:0]  in_data = '0;
  logic               in_ready, out_valid, sop, eop, evt_valid;
  logic [DATA_W-1:0]  out_data;
  logic [IDX_W-1:0]   evt_index;
  logic [BYTES_W-1:0] evt_bytes;

  rx_ring_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cfg_load_i(cfg_load),
    .cfg_base_i(c_base), .cfg_buf_beats_i(c_buf), .cfg_buf_count_i(c_cnt),
    .cfg_pkt_beats_i(c_pkt), .cfg_port_i(c_port), .cfg_dev_i(c_dev),
    .cfg_timeout_i(c_tmo), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_sop_o(sop), .out_eop_o(eop), .evt_valid_o(evt_valid),
    .evt_index_o(evt_index), .evt_bytes_o(evt_bytes)
  );

  int n_chk = 0, n_bad = 0;

  // reference state, built from the requirements
  logic [ADDR_W-1:0] s_base = '0;
  int s_buf = 1, s_cnt = 1, s_pkt = 1, s_tmo = 0;
  logic [PORT_W-1:0] s_port = '0;
  logic s_dev = 1'b0;
  int m_idx = 0, m_off = 0, m_cnt = 0, m_left = 0;
  bit m_body = 0, m_evt = 0, m_wrapped = 0;
  int m_evt_idx = 0, m_evt_bytes = 0;
  string m_evt_tag = "", hdr_tag = "R4";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_hdr(input int len);
    logic [63:0] a;
    a = {16'b0, s_base} + 64'((longint'(m_idx) * s_buf + m_off) * 8);
    return {s_dev, s_port, a[47:0], 8'(len)};
  endfunction

  task automatic close_buf(input int bytes, input string tag);
    m_evt = 1;
    m_evt_idx = m_idx;
    m_evt_bytes = bytes;
    m_off = 0;
    if (m_idx == s_cnt - 1) begin
      m_evt_tag = {tag, " R7 wrap"};
      m_idx = 0;
      m_wrapped = 1;
    end else begin
      m_evt_tag = tag;
      m_idx++;
    end
  endtask

  task automatic step(input bit v, input logic [63:0] d);
    int room, len;
    bit sop_e, fire;
    in_valid = v;
    in_data = d;
    #1;
    chk(m_evt ? m_evt_tag : "R9 no spurious event", 64'(evt_valid), 64'(m_evt));
    if (m_evt) begin
      chk({m_evt_tag, " index"}, 64'(evt_index), 64'(m_evt_idx));
      chk({m_evt_tag, " bytes"}, 64'(evt_bytes), 64'(m_evt_bytes));
    end
    room = s_buf - m_off;
    len = (room < s_pkt) ? room : s_pkt;
    sop_e = en && !m_body && v;
    fire = en && m_body && v;
    chk("R3 in_ready", 64'(in_ready), 64'(en && m_body));
    chk("R2 R3 out_valid", 64'(out_valid), 64'(en && v));
    chk("R3 sop", 64'(sop), 64'(sop_e));
    if (sop_e)
      chk((m_idx == 0 && m_off == 0 && m_wrapped) ? "R7 post-wrap header" : {hdr_tag, " header"},
          out_data, exp_hdr(len));
    if (fire) begin
      chk("R3 payload passthrough", out_data, d);
      chk("R5 eop", 64'(eop), 64'(m_left == 1));
    end else begin
      chk("R5 eop idle", 64'(eop), 64'(0));
    end
    m_evt = 0;
    if (cfg_load && !en) begin
      s_base = c_base; s_buf = int'(c_buf); s_cnt = int'(c_cnt); s_pkt = int'(c_pkt);
      s_port = c_port; s_dev = c_dev; s_tmo = int'(c_tmo);
    end
    if (!en || !rst_n) begin
      m_body = 0; m_left = 0; m_idx = 0; m_off = 0; m_cnt = 0; m_wrapped = 0;
    end else if (sop_e) begin
      m_body = 1; m_left = len; m_cnt = 0;
    end else if (fire) begin
      m_cnt = 0;
      m_left--;
      if (m_left == 0) m_body = 0;
      if (m_off + 1 == s_buf) close_buf(s_buf * 8, "R6 full event");
      else m_off++;
    end else if (!m_body && !v && m_off != 0) begin
      if (s_tmo != 0 && m_cnt + 1 == s_tmo) begin
        close_buf(m_off * 8, "R8 timeout event");
        m_cnt = 0;
      end else m_cnt++;
    end else begin
      m_cnt = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) step(1'b1, {$urandom, $urandom});
  endtask

  task automatic set_cfg(input logic [47:0] b, input int bf, input int cn, input int pk,
                         input int pt, input bit dv, input int tm);
    c_base = b; c_buf = BUF_W'(bf); c_cnt = IDX_W'(cn); c_pkt = LEN_W'(pk);
    c_port = PORT_W'(pt); c_dev = dv; c_tmo = TMO_W'(tm);
    cfg_load = 1'b1;
    step(1'b0, '0);
    cfg_load = 1'b0;
  endtask

  task automatic rand_round(input int pct, input int cycles);
    en = 1'b0;
    step(1'b0, '0);
    set_cfg({$urandom, $urandom}, $urandom_range(12, 1), $urandom_range(4, 1),
            $urandom_range(9, 1), $urandom_range(127), 1'($urandom),
            ($urandom_range(3) == 0) ? 0 : $urandom_range(15, 1));
    en = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      if ($urandom_range(39) == 0) idle($urandom_range(s_tmo + 3));
      step($urandom_range(99) < pct, {$urandom, $urandom});
    end
  endtask

  initial begin
    #(64'd200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    step(1'b0, '0);
    chk("R1 in_ready after reset", 64'(in_ready), 64'(0));
    chk("R1 out_valid after reset", 64'(out_valid), 64'(0));
    chk("R1 evt_valid after reset", 64'(evt_valid), 64'(0));
    rst_n = 1'b1;
    step(1'b0, '0);

    // R1 defaults: 1-beat buffers, single-buffer ring, 1-beat packets
    en = 1'b1;
    hdr_tag = "R1 default";
    beats(6);
    idle(2);

    // R2 disabled: valid input must not pass
    en = 1'b0;
    hdr_tag = "R2";
    beats(3);

    // R5 shortening, R6 full, R7 wrap
    set_cfg(48'h1000, 6, 3, 4, 5, 1'b1, 10);
    en = 1'b1;
    hdr_tag = "R4 R5";
    beats(40);
    idle(3);

    // R8 timeout and R9 mid-packet stall
    hdr_tag = "R8";
    beats(4);
    idle(20);
    beats(1);
    idle(14);
    // R9 restart: gaps just under the timeout
    hdr_tag = "R9";
    for (int i = 0; i < 8; i++) begin
      beats(2);
      idle(8);
    end
    idle(15);
    // R9 empty buffer stays quiet
    idle(40);

    // R2 load while enabled is ignored
    hdr_tag = "R2 load-ignored";
    c_base = 48'hdead_0000; c_buf = 16'd3; c_pkt = 8'd1; c_port = 7'd99; c_dev = 1'b0;
    cfg_load = 1'b1;
    step(1'b0, '0);
    cfg_load = 1'b0;
    beats(10);

    // R10 disable mid-buffer then resume at base
    en = 1'b0;
    idle(2);
    en = 1'b1;
    hdr_tag = "R10 re-enable";
    beats(5);
    idle(12);

    // R9 timeout 0 disables closing
    en = 1'b0;
    step(1'b0, '0);
    set_cfg(48'h8000, 8, 2, 3, 9, 1'b0, 0);
    en = 1'b1;
    hdr_tag = "R9 tmo0";
    beats(3);
    idle(120);

    // random ring shapes and traffic
    hdr_tag = "R4 random";
    for (int r = 0; r < 12; r++) rand_round((r % 3 == 0) ? 100 : ((r % 3 == 1) ? 60 : 25), 400);
    idle(20);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule